// File: doc/BRIEF.md
# Tri-Speed Ethernet Transmit Clock Selector

This block produces the transmit clock for a tri-speed Ethernet MAC that feeds an RGMII PHY. From a single 125 MHz reference it delivers either the reference itself (1000 Mb/s), a divide-by-5 clock at 25 MHz (100 Mb/s) or a divide-by-50 clock at 2.5 MHz (10 Mb/s). The rate is chosen from two MAC mode flags with a fixed priority: the gigabit flag wins, then the 10 Mb/s enable, and 100 Mb/s is the fallback.

Both flags are brought into the reference domain through a two-stage synchronizer. A requested rate takes effect only at a point where the running clock has just finished a low phase, and the new clock begins with a full pulse. As a result, the output never shows a shortened high or low phase. A two-bit status output reports the rate in force, and it moves at the moment the switch is made. The divided clocks are driven from flops. The full-rate clock passes through a gate whose enable changes only while the reference is low.

Top module: `txclk_rate_sel`

## Requirements
- R1: When `gig_mode_i` is high, the output follows the 125 MHz reference (one half-period high, one low) whatever `slow_en_i` is, and `rate_o` reads 2'b10.
- R2: When `gig_mode_i` is low and `slow_en_i` is high, the output is the reference divided by 50, with 25 reference periods high then 25 low, and `rate_o` reads 2'b00.
- R3: When both flags are low, the output is the reference divided by 5, with 2 reference periods high then 3 low, and `rate_o` reads 2'b01.
- R4: In 100 Mb/s mode the output high time lies between 16 ns and 24 ns inclusive for an 8 ns reference. A parameter set whose fast high time falls outside that window is rejected at elaboration.
- R5: `rate_o` encodes 00 = 10 Mb/s, 01 = 100 Mb/s and 10 = 1000 Mb/s. It changes only when the switch is made. It keeps the old code through every remaining pulse of a divided old clock, and shows the new code before the first new-rate pulse ends.
- R6: A rate change is glitch-free. The switch happens only once the old clock has completed a low phase. Every high pulse around a change has the full length of either the old or the new rate. Every low gap is at least as long as the shorter of the two rates' low phases.
- R7: An asynchronous active-low reset clears the dividers, holds the output low and sets `rate_o` to 00. After release, the block starts in the mode selected by the flags.
- R8: The flags pass through a two-flop synchronizer before use. After reset release, the output stays low for the first two reference cycles while the synchronizer fills.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk_i | input | 1 | 125 MHz reference clock |
| rst_n_i | input | 1 | Asynchronous reset, active low |
| gig_mode_i | input | 1 | MAC gigabit-mode flag (highest priority) |
| slow_en_i | input | 1 | MAC 10 Mb/s enable |
| tx_clk_o | output | 1 | Transmit clock to the MAC and PHY |
| rate_o | output | 2 | Rate in force: 00 = 10M, 01 = 100M, 10 = 1G |

## Verification
The bench builds the block with its default parameters: fast divider 5 with 2 high cycles, slow divider 50 with 25 high cycles, and two synchronizer stages. The slowest period is therefore only 100 half-cycles long, and every one of the ten ordered changes between distinct rates can be run end to end. The bench samples the output once in each reference half-period. From the parameter values it works out the exact high and low run lengths, in half-periods, for each rate. It then compares them, and the status code, in steady state, through every transition, at reset and across the startup window.

// File: rtl/txsel_pkg.sv
package txsel_pkg;

   // Rate codes; the numeric values are the status encoding seen at rate_o.
   typedef enum logic [1:0] {
      RATE_10M  = 2'b00,
      RATE_100M = 2'b01,
      RATE_1G   = 2'b10,
      RATE_NONE = 2'b11
   } rate_e;

   // Gigabit flag dominates, then the slow enable, else 100M.
   function automatic rate_e pick_rate(input logic gig, input logic slow);
      if (gig)
         return RATE_1G;
      else if (slow)
         return RATE_10M;
      else
         return RATE_100M;
   endfunction

endpackage

// File: rtl/txsel_sync.sv
module txsel_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 2
) (
   input  logic             clk_i,
   input  logic             rst_n_i,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   localparam int CHAIN_W = STAGES * WIDTH;

   logic [CHAIN_W-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("txsel_sync: at least two stages are required");
      end
   endgenerate

   // Shift register: newest sample enters at the bottom, oldest leaves at the top.
   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i)
         chain_q <= '0;
      else
         chain_q <= {chain_q[CHAIN_W-WIDTH-1:0], d_i};
   end

   assign q_o = chain_q[CHAIN_W-1 -: WIDTH];

endmodule

// File: rtl/txsel_ctrl.sv
module txsel_ctrl
   import txsel_pkg::*;
#(
   parameter int FAST_DIV    = 5,
   parameter int FAST_HIGH   = 2,
   parameter int SLOW_DIV    = 50,
   parameter int SLOW_HIGH   = 25,
   parameter int SYNC_STAGES = 2
) (
   input  logic  clk_i,
   input  logic  rst_n_i,
   input  rate_e req_i,
   output logic  div_clk_o,
   output logic  gig_arm_o,
   output rate_e rate_o
);

   localparam int MAX_DIV = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
   localparam int CNT_W   = $clog2(MAX_DIV);
   localparam int WARM_W  = $clog2(SYNC_STAGES + 1);

   typedef logic [CNT_W-1:0] cnt_t;

   localparam cnt_t FAST_LAST = cnt_t'(FAST_DIV - 1);
   localparam cnt_t SLOW_LAST = cnt_t'(SLOW_DIV - 1);
   localparam cnt_t FAST_HI   = cnt_t'(FAST_HIGH);
   localparam cnt_t SLOW_HI   = cnt_t'(SLOW_HIGH);

   function automatic cnt_t last_of(input rate_e r);
      return (r == RATE_10M) ? SLOW_LAST : FAST_LAST;
   endfunction

   function automatic cnt_t hi_of(input rate_e r);
      return (r == RATE_10M) ? SLOW_HI : FAST_HI;
   endfunction

   rate_e             cur_q, cur_d;
   rate_e             rate_q, rate_d;
   cnt_t              cnt_q, cnt_d;
   logic              div_q, div_d;
   logic              arm_q, arm_d;
   logic [WARM_W-1:0] warm_q;
   logic              warm_done;
   logic              divided;
   logic              at_edge;
   logic              take;

   assign warm_done = (warm_q == WARM_W'(SYNC_STAGES));
   assign divided   = (cur_q == RATE_10M) || (cur_q == RATE_100M);

   // Safe switch points: startup once the synchronizer is full, any edge in
   // gigabit mode (the gate closes on the following low half), and the last
   // low cycle of a divided period.
   always_comb begin
      case (cur_q)
         RATE_NONE: at_edge = warm_done;
         RATE_1G:   at_edge = 1'b1;
         default:   at_edge = (cnt_q == last_of(cur_q));
      endcase
      take = at_edge && (req_i != cur_q);
   end

   always_comb begin
      cur_d  = cur_q;
      rate_d = rate_q;
      cnt_d  = cnt_q;
      div_d  = div_q;
      arm_d  = arm_q;
      if (take) begin
         cur_d  = req_i;
         rate_d = req_i;
         if (req_i == RATE_1G) begin
            cnt_d = '0;
            div_d = 1'b0;
            arm_d = 1'b1;
         end else if (cur_q == RATE_1G) begin
            // Spend one full low cycle while the gate closes, then wrap to a fresh high.
            cnt_d = last_of(req_i);
            div_d = 1'b0;
            arm_d = 1'b0;
         end else begin
            cnt_d = '0;
            div_d = 1'b1;
            arm_d = 1'b0;
         end
      end else if (divided) begin
         cnt_d = at_edge ? '0 : cnt_q + cnt_t'(1);
         div_d = (cnt_d < hi_of(cur_q));
      end
   end

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         cur_q  <= RATE_NONE;
         rate_q <= RATE_10M;
         cnt_q  <= '0;
         div_q  <= 1'b0;
         arm_q  <= 1'b0;
         warm_q <= '0;
      end else begin
         cur_q  <= cur_d;
         rate_q <= rate_d;
         cnt_q  <= cnt_d;
         div_q  <= div_d;
         arm_q  <= arm_d;
         if (!warm_done)
            warm_q <= warm_q + WARM_W'(1);
      end
   end

   assign div_clk_o = div_q;
   assign gig_arm_o = arm_q;
   assign rate_o    = rate_q;

   // Checker: length of the current high run of the divided clock.
   cnt_t hrun_q;
   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i)
         hrun_q <= '0;
      else
         hrun_q <= div_q ? hrun_q + cnt_t'(1) : '0;
   end

   AST_FAST_HIGH_RUN: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      ($fell(div_q) && cur_q == RATE_100M && $past(cur_q) == RATE_100M) |-> hrun_q == FAST_HI) // R3
      else $error("100M high run length wrong");

   AST_SLOW_HIGH_RUN: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      ($fell(div_q) && cur_q == RATE_10M && $past(cur_q) == RATE_10M) |-> hrun_q == SLOW_HI) // R2
      else $error("10M high run length wrong");

   AST_SWITCH_FROM_LOW: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (!$stable(cur_q) && ($past(cur_q) == RATE_10M || $past(cur_q) == RATE_100M)) |-> !$past(div_q)) // R6
      else $error("divided clock left while high");

   AST_RATE_ON_SWITCH: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      !$stable(rate_q) |-> !$stable(cur_q)) // R5
      else $error("status moved without a switch");

endmodule

// File: rtl/txsel_outgate.sv
module txsel_outgate (
   input  logic clk_i,
   input  logic rst_n_i,
   input  logic arm_i,
   input  logic div_clk_i,
   output logic tx_clk_o
);

   logic open_q;

   // Enable retimed on the falling edge so it only moves while the reference is low.
   always_ff @(negedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i)
         open_q <= 1'b0;
      else
         open_q <= arm_i;
   end

   assign tx_clk_o = (clk_i & open_q) | div_clk_i;

   AST_SINGLE_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      !(open_q && div_clk_i)) // R6
      else $error("gate and divider both active");

   AST_GATE_OPENS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      $rose(open_q) |-> (!div_clk_i && !$past(div_clk_i))) // R6
      else $error("gate opened next to a divided pulse");

endmodule

// File: rtl/txclk_rate_sel.sv
module txclk_rate_sel
   import txsel_pkg::*;
#(
   parameter int FAST_DIV     = 5,
   parameter int FAST_HIGH    = 2,
   parameter int SLOW_DIV     = 50,
   parameter int SLOW_HIGH    = 25,
   parameter int SYNC_STAGES  = 2,
   parameter int REF_PS       = 8000,
   parameter int HIGH_MIN_PS  = 16000,
   parameter int HIGH_MAX_PS  = 24000
) (
   input  logic       ref_clk_i,
   input  logic       rst_n_i,
   input  logic       gig_mode_i,
   input  logic       slow_en_i,
   output logic       tx_clk_o,
   output logic [1:0] rate_o
);

   localparam int FAST_HIGH_PS = FAST_HIGH * REF_PS;

   generate
      if (FAST_HIGH < 1 || FAST_HIGH >= FAST_DIV) begin : g_bad_fast
         $error("txclk_rate_sel: fast high count must lie inside the fast period");
      end
      if (SLOW_HIGH < 1 || SLOW_HIGH >= SLOW_DIV) begin : g_bad_slow
         $error("txclk_rate_sel: slow high count must lie inside the slow period");
      end
      // R4: the 100M high time must fit the PHY window.
      if (FAST_HIGH_PS < HIGH_MIN_PS || FAST_HIGH_PS > HIGH_MAX_PS) begin : g_bad_window
         $error("txclk_rate_sel: 100M high time outside the allowed window");
      end
   endgenerate

   logic [1:0] flags_s;
   rate_e      req_w;
   rate_e      rate_w;
   logic       div_clk_w;
   logic       arm_w;

   txsel_sync #(
      .STAGES (SYNC_STAGES),
      .WIDTH  (2)
   ) u_sync (
      .clk_i   (ref_clk_i),
      .rst_n_i (rst_n_i),
      .d_i     ({gig_mode_i, slow_en_i}),
      .q_o     (flags_s)
   );

   assign req_w = pick_rate(flags_s[1], flags_s[0]);

   txsel_ctrl #(
      .FAST_DIV    (FAST_DIV),
      .FAST_HIGH   (FAST_HIGH),
      .SLOW_DIV    (SLOW_DIV),
      .SLOW_HIGH   (SLOW_HIGH),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_ctrl (
      .clk_i     (ref_clk_i),
      .rst_n_i   (rst_n_i),
      .req_i     (req_w),
      .div_clk_o (div_clk_w),
      .gig_arm_o (arm_w),
      .rate_o    (rate_w)
   );

   txsel_outgate u_gate (
      .clk_i     (ref_clk_i),
      .rst_n_i   (rst_n_i),
      .arm_i     (arm_w),
      .div_clk_i (div_clk_w),
      .tx_clk_o  (tx_clk_o)
   );

   assign rate_o = rate_w;

   AST_STATUS_LEGAL: assert property (@(posedge ref_clk_i) disable iff (!rst_n_i)
      rate_o != 2'b11) // R5
      else $error("illegal status code");

endmodule

// File: tb/txclk_rate_sel_bench.sv
`timescale 1ns/1ps
module txclk_rate_sel_bench;

   localparam int CLK_PERIOD = 8;
   localparam int HALF       = CLK_PERIOD / 2;
   localparam int FD = 5, FH = 2, SD = 50, SH = 25, SYNC = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       gig = 1'b0;
   logic       slow = 1'b0;
   logic       tx_clk;
   logic [1:0] rate;

   int n_chk = 0;
   int n_bad = 0;

   always #(HALF) clk = ~clk;

   txclk_rate_sel #(
      .FAST_DIV (FD), .FAST_HIGH (FH), .SLOW_DIV (SD), .SLOW_HIGH (SH), .SYNC_STAGES (SYNC)
   ) u_txclk_rate_sel (
      .ref_clk_i  (clk),
      .rst_n_i    (rst_n),
      .gig_mode_i (gig),
      .slow_en_i  (slow),
      .tx_clk_o   (tx_clk),
      .rate_o     (rate)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Combo index: bit1 = gigabit flag, bit0 = slow enable.
   function automatic int code_of(input int c);
      if (c >= 2) return 2;
      else if (c == 1) return 0;
      else return 1;
   endfunction

   function automatic int hi_halves(input int code);
      if (code == 2) return 1;
      else if (code == 1) return 2 * FH;
      else return 2 * SH;
   endfunction

   function automatic int lo_halves(input int code);
      if (code == 2) return 1;
      else if (code == 1) return 2 * (FD - FH);
      else return 2 * (SD - SH);
   endfunction

   task automatic get_half(output logic v);
      @(posedge clk or negedge clk);
      #1;
      v = tx_clk;
   endtask

   task automatic set_flags(input int c);
      gig  = c[1];
      slow = c[0];
   endtask

   task automatic steady(input int c, input string tag);
      int   code = code_of(c);
      int   eh = hi_halves(code);
      int   el = lo_halves(code);
      int   hi, lo;
      logic v, prev;
      prev = 1'b1;
      for (int i = 0; i < 600; i++) begin
         get_half(v);
         if (!prev && v) break;
         prev = v;
      end
      for (int p = 0; p < 3; p++) begin
         hi = 1;
         for (int k = 0; k < 600; k++) begin
            get_half(v);
            if (!v) break;
            hi++;
         end
         lo = 1;
         for (int k = 0; k < 600; k++) begin
            get_half(v);
            if (v) break;
            lo++;
         end
         chk(hi == eh, {tag, " high halves"}, hi, eh);
         chk(lo == el, {tag, " low halves"}, lo, el);
         if (code == 1)
            chk(hi * HALF >= 16 && hi * HALF <= 24, "R4 100M high time ns", hi * HALF, 16);
      end
      chk(int'(rate) == code, {tag, " status"}, int'(rate), code);
   endtask

   task automatic trans(input int oc, input int nc);
      int   ocode = code_of(oc);
      int   ncode = code_of(nc);
      int   oh = hi_halves(ocode), ol = lo_halves(ocode);
      int   nh = hi_halves(ncode), nl = lo_halves(ncode);
      int   minlo = (ol < nl) ? ol : nl;
      int   run = 1;
      int   newruns = 0;
      bit   started = 1'b0;
      logic v, prev;
      get_half(prev);
      set_flags(nc);
      for (int i = 0; i < 3000 && newruns < 2; i++) begin
         get_half(v);
         if (v == prev) begin
            run++;
         end else begin
            if (started) begin
               if (prev) begin
                  chk(run == oh || run == nh, "R6 pulse length in change", run, nh);
                  if (run == nh) begin
                     chk(int'(rate) == ncode, "R5 status new by first new pulse", int'(rate), ncode);
                     newruns++;
                  end else if (ocode != 2) begin
                     chk(int'(rate) == ocode, "R5 status old during old pulse", int'(rate), ocode);
                  end
               end else begin
                  chk(run >= minlo, "R6 low gap in change", run, minlo);
               end
            end
            started = 1'b1;
            run = 1;
            prev = v;
         end
      end
      chk(newruns == 2, "R6 new rate reached", newruns, 2);
   endtask

   task automatic reset_and_start(input int c, input string tag);
      logic v;
      set_flags(c);
      @(negedge clk);
      #1 rst_n = 1'b0;
      for (int i = 0; i < 6; i++) begin
         get_half(v);
         chk(v == 1'b0, "R7 output low in reset", int'(v), 0);
      end
      chk(rate == 2'b00, "R7 status in reset", int'(rate), 0);
      @(negedge clk);
      #1 rst_n = 1'b1;
      for (int i = 0; i < 2 * SYNC; i++) begin
         get_half(v);
         chk(v == 1'b0, "R8 low while synchronizer fills", int'(v), 0);
      end
      steady(c, tag);
   endtask

   initial begin
      #(CLK_PERIOD * 190000);
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic v;
      // R7: state while held in reset from time zero
      repeat (3) @(posedge clk);
      #1;
      chk(tx_clk == 1'b0, "R7 reset output", int'(tx_clk), 0);
      chk(rate == 2'b00, "R7 reset status", int'(rate), 0);
      @(negedge clk);
      #1 rst_n = 1'b1;
      for (int i = 0; i < 2 * SYNC; i++) begin
         get_half(v);
         chk(v == 1'b0, "R8 startup low", int'(v), 0);
      end
      steady(0, "R3 100M start");

      // Sweep every ordered pair of distinct rates.
      for (int a = 0; a < 4; a++) begin
         for (int b = 0; b < 4; b++) begin
            if (code_of(a) != code_of(b)) begin
               set_flags(a);
               repeat (120) @(posedge clk);
               steady(a, code_of(a) == 2 ? "R1 gig steady" : (code_of(a) == 0 ? "R2 10M steady" : "R3 100M steady"));
               trans(a, b);
               steady(b, code_of(b) == 2 ? "R1 gig after change" : (code_of(b) == 0 ? "R2 10M after change" : "R3 100M after change"));
            end
         end
      end

      // R7: reset mid-run, restart directly in the flagged mode.
      reset_and_start(1, "R7 restart 10M");
      reset_and_start(3, "R1 restart gig with slow set");
      reset_and_start(0, "R7 restart 100M");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule